// File: doc/BRIEF.md
# Centisecond Stopwatch Counter with Display Freeze

This block keeps an elapsed time in four binary-coded-decimal digits, from 00.00 to 59.99 seconds. The lowest digit counts hundredths of a second. It moves forward by one on every cycle in which the single-cycle `tick_i` pulse is high, `run_i` is high and `clear_i` is low. An upstream divider produces `tick_i` at 100 Hz in the system clock domain, and the block has no gated clock. The digits form a mixed-radix chain with moduli 10, 10, 10 and 6. A carry passes upward whenever a lower digit rolls over, and the whole count returns to zero after 59.99.

The four digit outputs come from a display register, not from the live count. A two-state display controller has the states `DSP_TRACK` and `DSP_HOLD`. The transition *freeze* (TRACK to HOLD) is taken when `latch_i` is high. The transition *release* (HOLD to TRACK) is taken when `latch_i` is low. Both states stay in place while the input is unchanged. In `DSP_TRACK` the display register copies the live count on every clock. In `DSP_HOLD` it keeps the captured value while the live count goes on advancing. This gives lap-time display: the shown value is frozen, and on release the display jumps to the current running time.

Top module: `sw_timer`

## Requirements
- R1: After reset, all four digit outputs are 0.
- R2: A qualified tick (`tick_i`=1, `run_i`=1, `clear_i`=0) raises the live count by one hundredth of a second at that clock edge.
- R3: The hundredths digit rolls from 9 to 0 and carries into tenths in the same edge. Tenths rolls from 9 to 0 and carries into units in the same way.
- R4: Units rolling from 9 to 0 carries into the tens digit. The tens digit counts 0 to 5 only, so 59.99 plus one tick gives 00.00.
- R5: With `run_i`=0, ticks are ignored and every digit keeps its value.
- R6: `clear_i`=1 zeroes the live count and the display register at the next edge. It overrides a tick in the same cycle.
- R7: While `latch_i`=1 and `clear_i`=0, the digit outputs do not change, and the live count keeps advancing. After release, the display shows the advanced count.
- R8: While `latch_i`=0 and `clear_i`=0, the display register loads the live count at each edge, so the outputs trail the live count by one clock.
- R9: Each digit output is 4-bit BCD: `d_hund_o`, `d_tenth_o` and `d_unit_o` never exceed 9, and `d_tens_o` never exceeds 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle 100 Hz advance pulse |
| run_i | input | 1 | Counting allowed when high |
| clear_i | input | 1 | Synchronous clear of count and display |
| latch_i | input | 1 | Freeze displayed value when high |
| d_hund_o | output | 4 | Hundredths-of-second digit |
| d_tenth_o | output | 4 | Tenths-of-second digit |
| d_unit_o | output | 4 | Seconds digit |
| d_tens_o | output | 4 | Tens-of-seconds digit |

## Verification
Two events can fall in the same clock: a clear and a qualified tick, and a freeze and a tick that moves the live count. The bench raises `clear_i` and `tick_i` together, checks that the outputs read 00.00 one clock later, and checks that no stray hundredth appears. It also advances the live count while `latch_i` is high and compares the outputs against a bench model of both registers. The outputs must stay put during the hold, and after release they must show the count the model advanced in the meantime.

// File: rtl/sw_pkg.sv
package sw_pkg;
    localparam int DIGIT_W = 4;
    localparam int N_DIG   = 4;

    typedef enum logic {
        DSP_TRACK = 1'b0,
        DSP_HOLD  = 1'b1
    } dsp_state_t;

    function automatic int digit_mod(input int idx);
        return (idx == 3) ? 6 : 10;
    endfunction
endpackage

// File: rtl/sw_digit.sv
module sw_digit #(
    parameter int MOD = 10,
    parameter int W   = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] val,
    output logic         carry
);
    localparam logic [W-1:0] TOP = W'(MOD - 1);

    logic at_top;
    assign at_top = (val == TOP);
    assign carry  = inc & at_top;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            val <= '0;
        else if (clr)
            val <= '0;
        else if (inc)
            val <= at_top ? '0 : val + 1'b1;
    end

    // digit stays inside its radix
    assert_digit_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        val <= TOP);
    // rollover to zero at the top value
    assert_digit_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && val == TOP) |=> (val == '0));
    // step by one below the top value
    assert_digit_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && val != TOP) |=> (val == $past(val) + 1'b1));
    // no advance, no change
    assert_digit_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !clr) |=> $stable(val));
endmodule

// File: rtl/sw_disp_hold.sv
module sw_disp_hold
    import sw_pkg::*;
#(
    parameter int N = 4,
    parameter int W = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           latch,
    input  logic [N*W-1:0] live,
    output logic [N*W-1:0] disp
);
    dsp_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DSP_TRACK: if (latch)  state_d = DSP_HOLD;   // freeze
            DSP_HOLD:  if (!latch) state_d = DSP_TRACK;  // release
            default:   state_d = DSP_TRACK;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DSP_TRACK;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            disp <= '0;
        else if (clr)
            disp <= '0;
        else if (state_d == DSP_TRACK)
            disp <= live;
    end

    assert_disp_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (disp == '0));
    assert_disp_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (latch && !clr) |=> $stable(disp));
    assert_disp_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!latch && !clr) |=> (disp == $past(live)));
    assert_disp_state_R7: assert property (@(posedge clk) disable iff (!rst_n)
        latch |=> (state_q == DSP_HOLD));
endmodule

// File: rtl/sw_timer.sv
module sw_timer
    import sw_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_i,
    input  logic               run_i,
    input  logic               clear_i,
    input  logic               latch_i,
    output logic [DIGIT_W-1:0] d_hund_o,
    output logic [DIGIT_W-1:0] d_tenth_o,
    output logic [DIGIT_W-1:0] d_unit_o,
    output logic [DIGIT_W-1:0] d_tens_o
);
    localparam int TOT_W = N_DIG * DIGIT_W;

    logic [N_DIG:0]     chain;
    logic [TOT_W-1:0]   live_flat;
    logic [TOT_W-1:0]   disp_flat;

    assign chain[0] = tick_i & run_i & ~clear_i;

    for (genvar g = 0; g < N_DIG; g++) begin : g_dig
        sw_digit #(
            .MOD (digit_mod(g)),
            .W   (DIGIT_W)
        ) u_digit (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clear_i),
            .inc   (chain[g]),
            .val   (live_flat[g*DIGIT_W +: DIGIT_W]),
            .carry (chain[g+1])
        );
    end

    sw_disp_hold #(
        .N (N_DIG),
        .W (DIGIT_W)
    ) u_disp (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clear_i),
        .latch (latch_i),
        .live  (live_flat),
        .disp  (disp_flat)
    );

    assign d_hund_o  = disp_flat[0*DIGIT_W +: DIGIT_W];
    assign d_tenth_o = disp_flat[1*DIGIT_W +: DIGIT_W];
    assign d_unit_o  = disp_flat[2*DIGIT_W +: DIGIT_W];
    assign d_tens_o  = disp_flat[3*DIGIT_W +: DIGIT_W];

    // whole-count wrap after 59.99
    assert_full_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        chain[N_DIG] |=> (live_flat == '0));
    // gated ticks leave the live count alone
    assert_run_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !clear_i) |=> $stable(live_flat));
    // clear beats a simultaneous tick
    assert_clear_prio_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i && tick_i && run_i) |=> (live_flat == '0));
endmodule

// File: tb/sw_timer_tb.sv
module sw_timer_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_i = 1'b0, run_i = 1'b0, clear_i = 1'b0, latch_i = 1'b0;
    logic [3:0] d_hund_o, d_tenth_o, d_unit_o, d_tens_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    int m_live = 0;   // centiseconds, model of live count
    int m_disp = 0;   // model of display register

    always #4 clk = ~clk;

    sw_timer u_dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .run_i(run_i),
        .clear_i(clear_i), .latch_i(latch_i),
        .d_hund_o(d_hund_o), .d_tenth_o(d_tenth_o),
        .d_unit_o(d_unit_o), .d_tens_o(d_tens_o)
    );

    function automatic logic [15:0] to_bcd(input int cs);
        logic [15:0] r;
        r[3:0]   = 4'(cs % 10);
        r[7:4]   = 4'((cs / 10) % 10);
        r[11:8]  = 4'((cs / 100) % 10);
        r[15:12] = 4'(cs / 1000);
        return r;
    endfunction

    task automatic check(input string tag);
        logic [15:0] got, exp;
        got = {d_tens_o, d_unit_o, d_tenth_o, d_hund_o};
        exp = to_bcd(m_disp);
        n_chk++;
        if (got !== exp || d_hund_o > 9 || d_tenth_o > 9 || d_unit_o > 9 || d_tens_o > 5) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // drive at negedge, model at posedge, check at next negedge
    task automatic step(input bit t, input bit r, input bit c, input bit l, input string tag);
        int nl;
        tick_i = t; run_i = r; clear_i = c; latch_i = l;
        @(posedge clk);
        nl = m_live;
        if (c) nl = 0;
        else if (t && r) nl = (m_live + 1) % 6000;
        if (c) m_disp = 0;
        else if (!l) m_disp = m_live;
        m_live = nl;
        @(negedge clk);
        check(tag);
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got hang expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        check("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset release");

        // R2: single ticks, with idle gaps
        for (int i = 0; i < 5; i++) begin
            step(1, 1, 0, 0, "R2 tick");
            step(0, 1, 0, 0, "R2 gap");
        end
        // R5: run low ignores ticks
        for (int i = 0; i < 6; i++) step(1, 0, 0, 0, "R5 run low");
        // R3: carry hundredths -> tenths -> units
        for (int i = 0; i < 120; i++) step(1, 1, 0, 0, "R3 decimal carry");
        step(0, 0, 0, 0, "R3 settle");
        // R6: clear with a tick in the same cycle
        step(1, 1, 1, 0, "R6 clear beats tick");
        step(0, 1, 0, 0, "R6 after clear");
        // R7: hold while count advances, then release
        step(1, 1, 0, 0, "R8 follow");
        for (int i = 0; i < 37; i++) step(1, 1, 0, 1, "R7 frozen");
        step(0, 1, 0, 0, "R7 release");
        step(0, 1, 0, 0, "R8 follow after release");
        // R6: clear while held zeroes display too
        step(1, 1, 0, 1, "R7 frozen");
        step(0, 1, 1, 1, "R6 clear during hold");
        // R4: full run to 59.99 and wrap
        for (int i = 0; i < 5999; i++) step(1, 1, 0, 0, "R4 long count");
        step(0, 1, 0, 0, "R4 at 59.99");
        step(1, 1, 0, 0, "R4 wrap tick");
        step(0, 1, 0, 0, "R4 wrapped to 00.00");
        // constrained random mix
        for (int i = 0; i < 4000; i++) begin
            bit t, r, c;
            t = ($urandom % 2) == 0;
            r = ($urandom % 4) != 0;
            c = ($urandom % 60) == 0;
            if (($urandom % 25) == 0) latch_i = ~latch_i;
            step(t, r, c, latch_i, "R8 random mix");
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule